// File: doc/BRIEF.md
# Multi-Context Interrupt Claim Controller

This block gathers level-sensitive interrupt lines from a set of sources and hands them out to several contexts. A context is one hart running in one privilege mode. Software gives each source a priority and gives each context its own enable mask and its own threshold. Each context has one request line. That line goes high when the context can see a pending source whose priority is above its threshold.

A context services an interrupt in two steps. First it reads its claim register. The read returns the identifier of the most urgent pending source that the context has enabled. In the same clock edge that source moves from pending to in service. It then drops out of arbitration for every context. When the handler is done, software writes the same identifier back to the claim register. The source then leaves the in-service state, and its input line is sampled again on the following edge.

All configuration goes through one word-addressed register port. The top two address bits select a region. Region 0 holds priorities, with the low bits giving the source id. Region 1 holds enable masks, with the low bits giving the context. Region 2 holds per-context registers: the address low bit selects threshold (0) or claim/complete (1), and the bits above it give the context.

Top module: `irq_claim_ctrl`

## Requirements
- R1: After reset every priority, enable mask and threshold reads 0, no source is pending or in service, every request line is low and read data is 0.
- R2: A source whose priority is 0 is never returned by a claim and never raises a request line.
- R3: A claim read returns, one cycle after the read, the id of the enabled pending source with the largest priority; among equal priorities the lower id wins.
- R4: A claim read with no enabled pending source of nonzero priority returns 0 and changes no state.
- R5: A claimed source stops being pending, becomes in service, and is not returned to any context until it is completed.
- R6: Writing the id of an in-service source to the claim register of a context that enables it ends service; a source whose input is still high is pending again two edges after that write.
- R7: A completion write whose id is not in service, is out of range, or is disabled for the writing context is ignored.
- R8: A context's request line is high exactly when its best enabled pending source has a priority strictly above that context's threshold.
- R9: Enable masks are independent per context: a source enabled for one context does not affect another context's request or claim.
- R10: Priority (bits PRIO_W-1:0), enable mask (bit i for source i, bit 0 reads 0) and threshold read back as written, one cycle after the read.
- R11: A source that is in service is never pending at the same time, even while its input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NSRC | Level interrupt inputs; bit i-1 belongs to source id i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; ignored while reg_wr_i is high |
| reg_addr_i | input | ADDR_W | Word address: region in the top two bits, index below |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data, registered; holds the last read value |
| irq_o | output | NCTX | Per-context interrupt request |

## Verification
A pending or in-service bit left in the wrong state shows up directly at the ports. Either the next claim read returns a wrong id, or a request line changes level. The claim result appears one cycle after the read, and the request line moves in the same cycle as the state change. A stuck in-service bit is visible through a claim that keeps returning 0 while the input is high. A lost enable or threshold value shows up on the next readback or on the request line. Random traffic mixes claims, completions with valid and stray ids, and reconfiguration against a bench model, so a wrong arbitration tie or a wrong gating of the re-sample is caught within a few operations.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

   // Address regions selected by the two top address bits
   typedef enum logic [1:0] {
      RG_PRIO = 2'd0,
      RG_ENAB = 2'd1,
      RG_CTX  = 2'd2,
      RG_NONE = 2'd3
   } reg_region_e;

endpackage

// File: rtl/irqc_gate_bank.sv
module irqc_gate_bank #(
   parameter int unsigned NSRC = 8,
   parameter int unsigned IDW  = 4
) (
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [NSRC-1:0] src_i,
   input  logic            claim_vld_i,
   input  logic [IDW-1:0]  claim_id_i,
   input  logic            cmpl_vld_i,
   input  logic [IDW-1:0]  cmpl_id_i,
   output logic [NSRC:1]   pend_o,
   output logic [NSRC:1]   active_o
);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pend_o   <= '0;
         active_o <= '0;
      end else begin
         for (int s = 1; s <= NSRC; s++) begin
            if (claim_vld_i && claim_id_i == IDW'(s)) begin
               pend_o[s]   <= 1'b0;
               active_o[s] <= 1'b1;
            end else begin
               if (cmpl_vld_i && cmpl_id_i == IDW'(s))
                  active_o[s] <= 1'b0;
               if (src_i[s-1] && !pend_o[s] && !active_o[s])
                  pend_o[s] <= 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/irqc_ctx_arb.sv
module irqc_ctx_arb #(
   parameter int unsigned NSRC       = 8,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned IDW        = 4,
   parameter bit          TIE_LOW_ID = 1'b1
) (
   input  logic [NSRC:1]             pend_i,
   input  logic [NSRC:1]             en_i,
   input  logic [NSRC:1][PRIO_W-1:0] prio_i,
   input  logic [PRIO_W-1:0]         thr_i,
   output logic [IDW-1:0]            best_id_o,
   output logic                      irq_o
);

   logic [PRIO_W-1:0] best_p;

   if (TIE_LOW_ID) begin : g_tie_low
      always_comb begin
         best_p    = '0;
         best_id_o = '0;
         for (int s = 1; s <= NSRC; s++) begin
            if (pend_i[s] && en_i[s] && prio_i[s] > best_p) begin
               best_p    = prio_i[s];
               best_id_o = IDW'(s);
            end
         end
      end
   end else begin : g_tie_high
      always_comb begin
         best_p    = '0;
         best_id_o = '0;
         for (int s = 1; s <= NSRC; s++) begin
            if (pend_i[s] && en_i[s] && prio_i[s] != '0 && prio_i[s] >= best_p) begin
               best_p    = prio_i[s];
               best_id_o = IDW'(s);
            end
         end
      end
   end

   assign irq_o = best_p > thr_i;

endmodule

// File: rtl/irq_claim_ctrl.sv
module irq_claim_ctrl
   import irqc_pkg::*;
#(
   parameter int unsigned NSRC       = 8,
   parameter int unsigned NCTX       = 2,
   parameter int unsigned PRIO_W     = 3,
   parameter int unsigned ADDR_W     = 10,
   parameter int unsigned DATA_W     = 32,
   parameter bit          TIE_LOW_ID = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NSRC-1:0]   src_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [ADDR_W-1:0] reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   output logic [NCTX-1:0]   irq_o
);

   localparam int unsigned IDW   = $clog2(NSRC + 1);
   localparam int unsigned IDX_W = ADDR_W - 2;
   localparam int unsigned CTX_W = IDX_W - 1;

   if (NSRC < 1 || NSRC + 1 > DATA_W) begin : g_bad_nsrc
      $error("NSRC must be at least 1 and fit an enable word");
   end
   if (ADDR_W < 4 || (1 << IDX_W) <= NSRC) begin : g_bad_addr
      $error("ADDR_W too small for the source count");
   end
   if (NCTX < 1 || NCTX > (1 << CTX_W)) begin : g_bad_nctx
      $error("NCTX does not fit the context index field");
   end
   if (PRIO_W < 1 || PRIO_W > DATA_W) begin : g_bad_prio
      $error("PRIO_W out of range");
   end

   reg_region_e                  region;
   logic [IDX_W-1:0]             idx;
   logic [CTX_W-1:0]             ctx_sel;
   logic                         ctx_ok, rd_ok, ctx_reg;
   logic [NSRC:1][PRIO_W-1:0]    prio_q;
   logic [NCTX-1:0][NSRC:1]      en_q;
   logic [NCTX-1:0][PRIO_W-1:0]  thr_q;
   logic [NSRC:1]                pend, active;
   logic [NCTX-1:0][IDW-1:0]     best_id;
   logic [IDW-1:0]               sel_best, cmpl_id;
   logic [NSRC:1]                sel_en;
   logic [PRIO_W-1:0]            sel_thr;
   logic                         claim_rd, claim_vld, cmpl_hit, cmpl_ok, cmpl_vld;
   logic [DATA_W-1:0]            rd_val, rdata_q;

   assign region  = reg_region_e'(reg_addr_i[ADDR_W-1 -: 2]);
   assign idx     = reg_addr_i[IDX_W-1:0];
   assign ctx_sel = idx[IDX_W-1:1];
   assign ctx_ok  = 32'(ctx_sel) < NCTX;
   assign rd_ok   = reg_rd_i && !reg_wr_i;
   assign ctx_reg = region == RG_CTX && ctx_ok && idx[0];

   always_comb begin
      sel_best = '0;
      sel_en   = '0;
      sel_thr  = '0;
      for (int c = 0; c < NCTX; c++) begin
         if (ctx_sel == CTX_W'(c)) begin
            sel_best = best_id[c];
            sel_en   = en_q[c];
            sel_thr  = thr_q[c];
         end
      end
   end

   // claim and completion decode
   assign claim_rd  = rd_ok && ctx_reg;
   assign claim_vld = claim_rd && sel_best != '0;
   assign cmpl_id   = reg_wdata_i[IDW-1:0];
   assign cmpl_hit  = reg_wr_i && ctx_reg && reg_wdata_i[DATA_W-1:IDW] == '0;

   always_comb begin
      cmpl_ok = 1'b0;
      for (int s = 1; s <= NSRC; s++) begin
         if (cmpl_id == IDW'(s))
            cmpl_ok = active[s] && sel_en[s];
      end
   end
   assign cmpl_vld = cmpl_hit && cmpl_ok;

   // read mux
   always_comb begin
      rd_val = '0;
      unique case (region)
         RG_PRIO: begin
            for (int s = 1; s <= NSRC; s++)
               if (idx == IDX_W'(s)) rd_val = DATA_W'(prio_q[s]);
         end
         RG_ENAB: if (32'(idx) < NCTX) begin
            for (int c = 0; c < NCTX; c++)
               if (idx == IDX_W'(c)) rd_val = DATA_W'({en_q[c], 1'b0});
         end
         RG_CTX: if (ctx_ok) rd_val = idx[0] ? DATA_W'(sel_best) : DATA_W'(sel_thr);
         default: rd_val = '0;
      endcase
   end

   // configuration registers and read data
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         prio_q  <= '0;
         en_q    <= '0;
         thr_q   <= '0;
         rdata_q <= '0;
      end else begin
         if (rd_ok)
            rdata_q <= rd_val;
         if (reg_wr_i) begin
            for (int s = 1; s <= NSRC; s++)
               if (region == RG_PRIO && idx == IDX_W'(s))
                  prio_q[s] <= reg_wdata_i[PRIO_W-1:0];
            for (int c = 0; c < NCTX; c++) begin
               if (region == RG_ENAB && idx == IDX_W'(c))
                  en_q[c] <= reg_wdata_i[NSRC:1];
               if (region == RG_CTX && !idx[0] && ctx_sel == CTX_W'(c))
                  thr_q[c] <= reg_wdata_i[PRIO_W-1:0];
            end
         end
      end
   end

   assign reg_rdata_o = rdata_q;

   irqc_gate_bank #(.NSRC(NSRC), .IDW(IDW)) gate_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .src_i       (src_i),
      .claim_vld_i (claim_vld),
      .claim_id_i  (sel_best),
      .cmpl_vld_i  (cmpl_vld),
      .cmpl_id_i   (cmpl_id),
      .pend_o      (pend),
      .active_o    (active)
   );

   for (genvar c = 0; c < NCTX; c++) begin : g_ctx
      irqc_ctx_arb #(
         .NSRC(NSRC), .PRIO_W(PRIO_W), .IDW(IDW), .TIE_LOW_ID(TIE_LOW_ID)
      ) arb_i (
         .pend_i    (pend),
         .en_i      (en_q[c]),
         .prio_i    (prio_q),
         .thr_i     (thr_q[c]),
         .best_id_o (best_id[c]),
         .irq_o     (irq_o[c])
      );
   end

endmodule

// File: rtl/irqc_claim_chk.sv
module irqc_claim_chk #(
   parameter int unsigned NSRC   = 8,
   parameter int unsigned NCTX   = 2,
   parameter int unsigned PRIO_W = 3,
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 32
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      reg_wr_i,
   input logic                      reg_rd_i,
   input logic [ADDR_W-1:0]         reg_addr_i,
   input logic [DATA_W-1:0]         reg_wdata_i,
   input logic [DATA_W-1:0]         reg_rdata_o,
   input logic [NCTX-1:0]           irq_o,
   input logic [NSRC:1]             pend,
   input logic [NSRC:1]             active,
   input logic [NSRC:1][PRIO_W-1:0] prio_q
);

   localparam int unsigned IDX_W = ADDR_W - 2;

   logic ctx_claim_addr, claim_rd, cmpl_wr;
   logic rd_in_rng, act_at, pend_at, prio_nz_at, cmpl_act;

   assign ctx_claim_addr = reg_addr_i[ADDR_W-1 -: 2] == 2'd2 && reg_addr_i[0]
                           && 32'(reg_addr_i[IDX_W-1:1]) < NCTX;
   assign claim_rd = reg_rd_i && !reg_wr_i && ctx_claim_addr;
   assign cmpl_wr  = reg_wr_i && ctx_claim_addr;

   always_comb begin
      rd_in_rng  = 1'b0;
      act_at     = 1'b0;
      pend_at    = 1'b0;
      prio_nz_at = 1'b0;
      cmpl_act   = 1'b0;
      for (int s = 1; s <= NSRC; s++) begin
         if (reg_rdata_o == DATA_W'(s)) begin
            rd_in_rng  = 1'b1;
            act_at     = active[s];
            pend_at    = pend[s];
            prio_nz_at = prio_q[s] != '0;
         end
         if (reg_wdata_i == DATA_W'(s))
            cmpl_act = active[s];
      end
   end

   // R5
   claim_commit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_rd |=> (reg_rdata_o == '0) || (rd_in_rng && act_at && !pend_at));

   // R2
   claim_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      claim_rd |=> (reg_rdata_o == '0) || (rd_in_rng && prio_nz_at));

   // R11
   pend_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pend & active) == '0);

   // R8
   irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|irq_o) |-> (|pend));

   // R7
   stray_cmpl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmpl_wr && !cmpl_act) |=> $stable(active));

   // R4
   empty_claim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (claim_rd && pend == '0) |=> (reg_rdata_o == '0 && $stable(active)));

endmodule

bind irq_claim_ctrl irqc_claim_chk #(
   .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) chk_i (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .reg_wr_i    (reg_wr_i),
   .reg_rd_i    (reg_rd_i),
   .reg_addr_i  (reg_addr_i),
   .reg_wdata_i (reg_wdata_i),
   .reg_rdata_o (reg_rdata_o),
   .irq_o       (irq_o),
   .pend        (pend),
   .active      (active),
   .prio_q      (prio_q)
);

// File: tb/irq_claim_ctrl_tb_top.sv
module irq_claim_ctrl_tb_top;

   localparam int  NSRC = 8;
   localparam int  NCTX = 2;
   localparam int  PRIO_W = 3;
   localparam int  ADDR_W = 10;
   localparam int  DATA_W = 32;
   localparam time CLK_PERIOD = 10;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   src = '0;
   logic              wr = 1'b0, rd = 1'b0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   wire  [DATA_W-1:0] rdata;
   wire  [NCTX-1:0]   irq;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_claim_ctrl #(
      .NSRC(NSRC), .NCTX(NCTX), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_wr_i(wr), .reg_rd_i(rd),
      .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
   );

   // bench model
   int unsigned m_prio [1:NSRC];
   bit          m_en   [NCTX][1:NSRC];
   int unsigned m_thr  [NCTX];
   bit          m_pend [1:NSRC];
   bit          m_act  [1:NSRC];
   longint      last_rd;
   int          n_chk = 0, n_fail = 0;

   function automatic int f_best(int c);
      int unsigned bp = 0;
      int bi = 0;
      for (int s = 1; s <= NSRC; s++)
         if (m_pend[s] && m_en[c][s] && m_prio[s] > bp) begin
            bp = m_prio[s];
            bi = s;
         end
      return bi;
   endfunction

   function automatic bit f_irq(int c);
      int bi = f_best(c);
      return bi != 0 && m_prio[bi] > m_thr[c];
   endfunction

   function automatic longint f_mask(int c);
      longint m = 0;
      for (int s = 1; s <= NSRC; s++) if (m_en[c][s]) m |= (64'd1 << s);
      return m;
   endfunction

   function automatic logic [ADDR_W-1:0] a_prio(int s);
      return {2'd0, 8'(s)};
   endfunction
   function automatic logic [ADDR_W-1:0] a_en(int c);
      return {2'd1, 8'(c)};
   endfunction
   function automatic logic [ADDR_W-1:0] a_thr(int c);
      return {2'd2, 7'(c), 1'b0};
   endfunction
   function automatic logic [ADDR_W-1:0] a_clm(int c);
      return {2'd2, 7'(c), 1'b1};
   endfunction

   task automatic check(string req, longint act, longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // one clock with the currently driven inputs, model updated alongside
   task automatic tick();
      int  region = int'(addr[ADDR_W-1 -: 2]);
      int  idx    = int'(addr[ADDR_W-3:0]);
      int  c      = idx >> 1;
      int  claim_id = 0, cmpl_c = -1, cmpl_id = 0;
      bit  old_p [1:NSRC] = m_pend;
      bit  old_a [1:NSRC] = m_act;
      if (rd && !wr) begin
         last_rd = 0;
         if (region == 0 && idx >= 1 && idx <= NSRC) last_rd = m_prio[idx];
         if (region == 1 && idx < NCTX) last_rd = f_mask(idx);
         if (region == 2 && c < NCTX) begin
            if (idx % 2 == 1) begin
               claim_id = f_best(c);
               last_rd = claim_id;
            end else last_rd = m_thr[c];
         end
      end
      if (wr && region == 2 && c < NCTX && idx % 2 == 1 && wdata >= 1 && wdata <= NSRC) begin
         cmpl_c = c;
         cmpl_id = int'(wdata);
      end
      @(posedge clk);
      for (int s = 1; s <= NSRC; s++) begin
         if (claim_id == s) begin
            m_pend[s] = 1'b0;
            m_act[s]  = 1'b1;
         end else begin
            if (cmpl_c >= 0 && cmpl_id == s && old_a[s] && m_en[cmpl_c][s]) m_act[s] = 1'b0;
            if (src[s-1] && !old_p[s] && !old_a[s]) m_pend[s] = 1'b1;
         end
      end
      if (wr) begin
         if (region == 0 && idx >= 1 && idx <= NSRC) m_prio[idx] = int'(wdata[PRIO_W-1:0]);
         if (region == 1 && idx < NCTX)
            for (int s = 1; s <= NSRC; s++) m_en[idx][s] = wdata[s];
         if (region == 2 && c < NCTX && idx % 2 == 0) m_thr[c] = int'(wdata[PRIO_W-1:0]);
      end
      @(negedge clk);
      rd = 1'b0;
      wr = 1'b0;
      for (int k = 0; k < NCTX; k++) check("R8 irq", irq[k], f_irq(k));
   endtask

   task automatic do_wr(logic [ADDR_W-1:0] a, longint d);
      addr = a; wdata = DATA_W'(d); wr = 1'b1;
      tick();
   endtask

   task automatic do_rd(logic [ADDR_W-1:0] a, string req);
      addr = a; rd = 1'b1;
      tick();
      check(req, rdata, last_rd);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog (all requirements): actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      for (int s = 1; s <= NSRC; s++) begin m_prio[s] = 0; m_pend[s] = 0; m_act[s] = 0; end
      for (int k = 0; k < NCTX; k++) begin
         m_thr[k] = 0;
         for (int s = 1; s <= NSRC; s++) m_en[k][s] = 0;
      end
      last_rd = 0;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 irq", irq, 0);
      check("R1 rdata", rdata, 0);
      rst_n = 1'b1;
      @(negedge clk);
      do_rd(a_prio(3), "R1 prio");
      do_rd(a_en(0), "R1 enable");
      do_rd(a_thr(1), "R1 threshold");

      do_wr(a_prio(1), 2);
      do_wr(a_prio(2), 5);
      do_wr(a_prio(3), 5);
      do_wr(a_prio(4), 0);
      do_wr(a_en(0), 'h1FE);
      do_wr(a_en(1), 'h00A);
      do_rd(a_prio(2), "R10 prio");
      check("R10 prio literal", rdata, 5);
      do_rd(a_en(1), "R10 enable");
      check("R10 enable literal", rdata, 'h00A);

      // R2 priority-0 source only
      src = 8'b0000_1000;
      tick(); tick();
      do_rd(a_clm(0), "R2 claim");
      check("R2 claim literal", rdata, 0);
      check("R2 irq literal", irq, 0);

      // R3 tie between ids 2 and 3
      src = 8'b0000_1110;
      tick();
      do_rd(a_clm(0), "R3 claim");
      check("R3 tie literal", rdata, 2);
      // R9 ctx1 does not enable id 2; R5 id 2 gone anyway
      do_rd(a_clm(1), "R5 claim");
      check("R5 other ctx literal", rdata, 3);
      do_rd(a_clm(0), "R4 claim");
      check("R4 empty literal", rdata, 0);
      tick(); tick();
      do_rd(a_clm(0), "R11 claim");
      check("R11 no re-pend literal", rdata, 0);

      // R7 stray completions
      do_wr(a_clm(1), 2);
      do_wr(a_clm(0), 6);
      do_wr(a_clm(0), 'h102);
      tick();
      do_rd(a_clm(0), "R7 claim");
      check("R7 ignored literal", rdata, 0);

      // R6 completion then re-sample
      do_wr(a_clm(0), 2);
      tick();
      do_rd(a_clm(0), "R6 claim");
      check("R6 re-pend literal", rdata, 2);
      src = 8'b0000_0001;
      do_wr(a_clm(0), 2);
      do_wr(a_clm(1), 3);
      tick(); tick();

      // R8 threshold, R9 per-context enables
      do_wr(a_thr(0), 4);
      check("R8 below threshold literal", irq[0], 0);
      check("R9 ctx1 literal", irq[1], 1);
      do_wr(a_thr(0), 1);
      check("R8 above threshold literal", irq[0], 1);
      do_rd(a_thr(0), "R10 threshold");

      // random phase
      for (int i = 0; i < 800; i++) begin
         int op = int'($urandom_range(0, 9));
         int c  = int'($urandom_range(0, NCTX - 1));
         int s  = int'($urandom_range(1, NSRC));
         src = NSRC'($urandom);
         case (op)
            0: do_wr(a_prio(s), $urandom_range(0, 7));
            1: do_wr(a_en(c), $urandom);
            2: do_wr(a_thr(c), $urandom_range(0, 7));
            3, 4: do_rd(a_clm(c), "R3 random claim");
            5, 6: do_wr(a_clm(c), $urandom_range(0, NSRC + 2));
            7: do_rd(a_prio(s), "R10 random prio");
            8: do_rd(a_en(c), "R9 random enable");
            default: tick();
         endcase
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule